// File: doc/BRIEF.md
# Soft-Stepping Digital Volume With Mute

This block scales a stream of signed audio samples by a digital attenuation set through a small control port. The control word carries a 7-bit attenuation code, a mute bit and a soft-step disable bit. Code 0 is unity gain and each code adds 0.5 dB of attenuation, so code 127 is -63.5 dB. The gain applied to the stream does not jump to a new setting. It moves one 0.5 dB code toward the requested setting on each pulse of a sample-rate tick. A settled flag shows when the applied code equals the requested one.

Muting ramps the applied code down to 127 and only then forces the output to zero. Unmuting starts from code 127 and ramps toward the requested code. When soft-stepping is switched off, every new setting takes effect without waiting for ticks.

Samples arrive and leave over valid/ready handshakes with one register stage in between. An input sample is taken when `in_valid` and `in_ready` are both high, and `in_ready` is high whenever the output register is empty or being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output sample and its valid stay frozen and no new input is taken. The gain used for a sample is the applied gain in the cycle the sample is accepted.

Top module: `soft_vol`

## Requirements
- R1: After reset the requested code is 0, mute is set, soft-stepping is on and the applied code is 127. `muted` and `gain_settled` are both 1, and any sample accepted comes out as 0.
- R2: The gain for applied code c is round(32768 * 10^(-c/40)), a factor with 15 fractional bits where unity is 32768. The output is (x*g + 16384) >> 15, using an arithmetic shift, saturated to the signed sample width.
- R3: With soft-stepping on, the applied code changes only on a cycle where `step_tick` is high. It then moves exactly one code toward the target and stays unchanged once it equals the target.
- R4: `gain_settled` is 1 exactly when the applied code equals the target. The target is 127 while mute is set and the requested code otherwise. With no new configuration write, a settled channel stays settled.
- R5: With soft-stepping on, setting mute keeps the output audible while the code ramps down. `muted` rises and the output becomes 0 only once the applied code reaches 127.
- R6: Clearing mute drops `muted` right after the write. The gain then rises from code 127 one code per tick.
- R7: If the requested code changes during a ramp, the next tick moves the applied code from its present value toward the new target.
- R8: With soft-stepping off, the applied code equals the new target from the second clock edge after the write, without any tick.
- R9: Output latency is one cycle. `in_ready` = !`out_valid` | `out_ready`. Under back-pressure `out_valid` and `out_data` hold.
- R10: At code 0, full-scale samples +32767 and -32768 pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the three configuration fields below |
| cfg_vol | input | 7 | Requested attenuation code, 0.5 dB per step |
| cfg_mute | input | 1 | Mute request |
| cfg_soft_off | input | 1 | 1 disables soft-stepping |
| step_tick | input | 1 | Sample-rate pulse, one ramp step each |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 16 | Signed scaled sample |
| gain_settled | output | 1 | Applied code equals target |
| muted | output | 1 | Mute reached, output forced to zero |

## Verification
The bench ramps through every code from 127 to 0 and checks the scaled output against an arithmetically computed gain at each code. This catches a ramp that skips codes, moves without a tick, or runs the wrong way. It also ticks past the target to catch a counter that overshoots or wraps.

It retargets in the middle of a ramp, which exposes a design that restarts from an end point. It mutes from a low code to catch a design that silences too early or never raises `muted`. A bypass write with no ticks exposes a design that still waits for the ramp. Full-scale samples at unity gain catch a broken rounding or saturation stage, and a stall with a queued input catches output data that changes under back-pressure.

// File: rtl/soft_vol_pkg.sv
package soft_vol_pkg;

  // 10^(-0.5/20) with 30 fractional bits: the linear factor of one code step
  localparam longint STEP_Q30 = 64'sd1013677644;

  // Linear gain of code c, with 15 fractional bits (unity = 32768)
  function automatic int gain_q15(input int c);
    longint acc;
    acc = 64'sd1 <<< 30;
    for (int i = 0; i < c; i++) acc = (acc * STEP_Q30) >>> 30;
    return int'((acc + (64'sd1 <<< 14)) >>> 15);
  endfunction

endpackage

// File: rtl/svol_gain_rom.sv
module svol_gain_rom #(
  parameter int CW = 7,
  parameter int GW = 16
) (
  input  logic [CW-1:0] code,
  output logic [GW-1:0] gain
);
  import soft_vol_pkg::*;

  localparam int DEPTH = 1 << CW;

  logic [GW-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int GV = gain_q15(i);
    assign tbl[i] = GW'(GV);
  end

  assign gain = tbl[code];

endmodule

// File: rtl/svol_ramp.sv
module svol_ramp #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_vol,
  input  logic          cfg_mute,
  input  logic          cfg_soft_off,
  input  logic          step_tick,
  output logic [CW-1:0] cur_code,
  output logic          settled,
  output logic          silent
);
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};

  logic [CW-1:0] vol_q;
  logic          mute_q;
  logic          soft_off_q;
  logic [CW-1:0] tgt;

  assign tgt     = mute_q ? MAXC : vol_q;
  assign settled = (cur_code == tgt);
  assign silent  = mute_q && (cur_code == MAXC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_q      <= '0;
      mute_q     <= 1'b1;
      soft_off_q <= 1'b0;
      cur_code   <= MAXC;
    end else begin
      if (cfg_we) begin
        vol_q      <= cfg_vol;
        mute_q     <= cfg_mute;
        soft_off_q <= cfg_soft_off;
      end
      if (soft_off_q) begin
        cur_code <= tgt;
      end else if (step_tick) begin
        if (cur_code < tgt)      cur_code <= cur_code + 1'b1;
        else if (cur_code > tgt) cur_code <= cur_code - 1'b1;
      end
    end
  end

  // R3
  no_idle_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_off_q && !step_tick) |=> $stable(cur_code));

  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_off_q) |=> ($stable(cur_code)
                       || ({1'b0, $past(cur_code)} + 1'b1 == {1'b0, cur_code})
                       || ({1'b0, cur_code} + 1'b1 == {1'b0, $past(cur_code)})));

  // R8
  bypass_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_off_q && !cfg_we) |=> settled);

  // R4
  hold_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !cfg_we) |=> settled);

endmodule

// File: rtl/svol_scale.sv
module svol_scale #(
  parameter int DW = 16,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [GW-1:0] gain,
  input  logic          silent,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int FRAC = GW - 1;
  localparam int PW   = DW + GW + 2;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW-1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW-1));
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC-1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;
  logic        [DW-1:0] sat;
  logic                 take;

  assign take     = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  always_comb begin
    prod    = PW'($signed(in_data)) * PW'($signed({1'b0, gain}));
    shifted = (prod + HALF) >>> FRAC;
    if (shifted > MAXV)      sat = MAXV[DW-1:0];
    else if (shifted < MINV) sat = MINV[DW-1:0];
    else                     sat = shifted[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= silent ? '0 : sat;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  silent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && silent) |=> (out_valid && out_data == '0));

endmodule

// File: rtl/soft_vol.sv
module soft_vol #(
  parameter int DW = 16,
  parameter int CW = 7,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_vol,
  input  logic          cfg_mute,
  input  logic          cfg_soft_off,
  input  logic          step_tick,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          gain_settled,
  output logic          muted
);
  logic [CW-1:0] cur_code;
  logic [GW-1:0] gain;
  logic          silent;

  svol_ramp #(.CW(CW)) u_ramp (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_vol      (cfg_vol),
    .cfg_mute     (cfg_mute),
    .cfg_soft_off (cfg_soft_off),
    .step_tick    (step_tick),
    .cur_code     (cur_code),
    .settled      (gain_settled),
    .silent       (silent)
  );

  svol_gain_rom #(.CW(CW), .GW(GW)) u_rom (
    .code (cur_code),
    .gain (gain)
  );

  svol_scale #(.DW(DW), .GW(GW)) u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .gain      (gain),
    .silent    (silent),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  assign muted = silent;

endmodule

// File: tb/soft_vol_tb.sv
module soft_vol_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_vol = '0;
  logic        cfg_mute = 1'b0;
  logic        cfg_soft_off = 1'b0;
  logic        step_tick = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        gain_settled;
  logic        muted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  soft_vol u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_vol(cfg_vol),
    .cfg_mute(cfg_mute), .cfg_soft_off(cfg_soft_off), .step_tick(step_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .gain_settled(gain_settled), .muted(muted)
  );

  function automatic int exp_out(input int x, input int c);
    longint g, p;
    g = longint'(32768.0 * (10.0 ** (-real'(c) / 40.0)));
    p = (longint'(x) * g + 64'sd16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic chk(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int vol, input bit mute, input bit soft_off);
    @(negedge clk);
    cfg_we = 1'b1; cfg_vol = 7'(vol); cfg_mute = mute; cfg_soft_off = soft_off;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step_tick = 1'b1;
      @(negedge clk); step_tick = 1'b0;
    end
  endtask

  task automatic send(input int x, output int y);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_data = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    y = int'($signed(out_data));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int y;
    int cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 muted", int'(muted), 1, 0);
    chk("R1 settled", int'(gain_settled), 1, 0);
    send(30000, y);
    chk("R1 zero out", y, 0, 0);

    // R6 unmute: muted drops at once, ramp from 127
    write_cfg(0, 1'b0, 1'b0);
    chk("R6 muted clear", int'(muted), 0, 0);
    chk("R4 not settled", int'(gain_settled), 0, 0);
    send(30000, y);
    chk("R6 start 127", y, exp_out(30000, 127), 1);
    cur = 127;
    // R2 R3 sweep every code
    for (int k = 0; k < 127; k++) begin
      tick(1);
      cur--;
      send(30000, y);
      chk("R2 R3 sweep", y, exp_out(30000, cur), 1);
      chk("R4 settled flag", int'(gain_settled), (cur == 0) ? 1 : 0, 0);
    end
    // R3 no overshoot past target
    tick(3);
    send(30000, y);
    chk("R3 hold at target", y, 30000, 0);
    // R10 full scale
    send(32767, y);
    chk("R10 pos full", y, 32767, 0);
    send(-32768, y);
    chk("R10 neg full", y, -32768, 0);
    send(-12345, y);
    chk("R2 unity neg", y, -12345, 0);

    // R7 retarget mid-ramp
    write_cfg(40, 1'b0, 1'b0);
    tick(10);
    send(30000, y);
    chk("R7 before", y, exp_out(30000, 10), 1);
    write_cfg(5, 1'b0, 1'b0);
    tick(1);
    send(30000, y);
    chk("R7 from current", y, exp_out(30000, 9), 1);
    tick(4);
    chk("R4 settled at 5", int'(gain_settled), 1, 0);
    tick(1);
    send(-20000, y);
    chk("R7 stays 5", y, exp_out(-20000, 5), 1);

    // R5 mute ramps down before silencing
    write_cfg(5, 1'b1, 1'b0);
    chk("R5 not yet muted", int'(muted), 0, 0);
    chk("R4 mute target", int'(gain_settled), 0, 0);
    tick(121);
    send(30000, y);
    chk("R5 audible 126", y, exp_out(30000, 126), 1);
    chk("R5 muted 126", int'(muted), 0, 0);
    tick(1);
    chk("R5 muted set", int'(muted), 1, 0);
    chk("R4 settled muted", int'(gain_settled), 1, 0);
    send(30000, y);
    chk("R5 silent", y, 0, 0);

    // R8 bypass: immediate without ticks
    write_cfg(20, 1'b0, 1'b1);
    chk("R8 muted clear", int'(muted), 0, 0);
    @(negedge clk);
    chk("R8 settled", int'(gain_settled), 1, 0);
    send(30000, y);
    chk("R8 gain 20", y, exp_out(30000, 20), 1);
    write_cfg(90, 1'b0, 1'b1);
    @(negedge clk);
    send(30000, y);
    chk("R8 gain 90", y, exp_out(30000, 90), 1);
    write_cfg(0, 1'b0, 1'b1);
    @(negedge clk);

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 drained", int'(out_valid), 0, 0);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 16'(1111);
    @(negedge clk);
    in_data = 16'(2222);
    chk("R9 latency", int'(out_valid), 1, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R9 in_ready low", int'(in_ready), 0, 0);
      chk("R9 data held", int'($signed(out_data)), 1111, 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next sample", int'($signed(out_data)), 2222, 0);
    @(negedge clk);
    chk("R9 empty", int'(out_valid), 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule